// File: doc/BRIEF.md
# Serial-bus clock and calendar register target

This block is the bus-facing part of a real-time clock. It sits on a two-wire serial bus (I2C) as a target and gives the bus master access to a bank of eight byte-wide timekeeping registers. SCL and SDA are brought into the fast system clock domain through a two-flop synchronizer. The block finds START and STOP conditions, matches its 7-bit device address 68h (address byte D0h writes, D1h reads) and acknowledges bytes by pulling SDA low. It drives SDA open-drain: the `sda_pull_o` output asks the pad to pull the line low.

All data moves through one register pointer that steps by one after each byte and wraps from the last register back to the first. In a write transfer, the first byte after the address loads the pointer and each later byte is stored at the pointer. In a read transfer, bytes are sent from the pointer onward. A STOP leaves the pointer where it is, so a later read carries on from the last position. A host-side tick port lets the timekeeping logic update any register directly. A supply-fault input stops any transfer at once, clears the pointer and makes the block deaf to the bus until the supply is good again.

The control is one state machine. ST_IDLE waits for a START. ST_ADDR shifts in the address byte. It moves to ST_ADDR_ACK when the address matches and to ST_IGNORE when it does not. ST_ADDR_ACK leads to ST_WR_BYTE for a write or to ST_RD_BYTE for a read. ST_WR_BYTE and ST_WR_ACK alternate for each received byte. ST_RD_BYTE and ST_RD_ACK alternate for each sent byte. ST_RD_ACK moves to ST_IGNORE when the master does not acknowledge. A START from any state except ST_LOCK goes to ST_ADDR. A STOP goes to ST_IDLE. A supply fault forces ST_LOCK from every state, and ST_LOCK returns to ST_IDLE once the fault is gone.

Top module: `rtc_bus_target`

## Requirements
- R1: After reset, SDA is released (`sda_pull_o` low), the pointer is 0 and all eight registers read back as 00h.
- R2: Address byte D0h or D1h is acknowledged (SDA low during the ninth SCL high phase). Any other address byte is not acknowledged, and the bytes that follow it are neither acknowledged nor stored, until the next START.
- R3: In a write, the first data byte loads its low three bits into the pointer. Each later data byte is stored in the register at the pointer and is acknowledged, and the pointer then steps by one.
- R4: In a read, the register at the pointer is sent MSB first, and the pointer steps by one after each byte. Register indices 0 to 7 are seconds, minutes, century/hours, day, date, month, years and control.
- R5: The pointer wraps from 7 to 0 in both reads and writes.
- R6: When the master does not acknowledge a read byte, the block sends no more data, and SDA stays released until the next START or STOP.
- R7: A STOP returns the block to idle without changing the pointer, so a read in a new transfer starts where the previous transfer left the pointer.
- R8: Raising `supply_fault_i` ends any transfer in progress, releases SDA and clears the pointer to 0.
- R9: While `supply_fault_i` is high, all bus activity is ignored: nothing is acknowledged and no register changes.
- R10: After `supply_fault_i` falls, the block accepts a new transfer that begins with a START.
- R11: A host tick write (`tick_we_i` with `tick_sel_i` and `tick_data_i`) updates the selected register. The new value can be read over the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain drive) |
| supply_fault_i | input | 1 | Supply out of tolerance: abort and lock out the bus |
| tick_we_i | input | 1 | Host write strobe for the register bank |
| tick_sel_i | input | 3 | Host write register index |
| tick_data_i | input | 8 | Host write data |

## Verification
The hardest case to reach is a supply fault that arrives in the middle of a write, just after the pointer byte was accepted. The bench raises the fault between two bytes of the same transfer. It then runs a complete write transfer while the fault is still high and checks that nothing is acknowledged. After the fault clears, it reads from pointer 0 without setting the pointer first, which shows that the pointer was cleared and that neither the aborted byte nor the locked-out byte reached the registers. A second case that is hard to reach is the NACK-terminated read. After the master declines a byte, the bench clocks one more full byte and checks that the line stays released throughout.

// File: rtl/rtc_bus_pkg.sv
package rtc_bus_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE,
        ST_LOCK
    } bus_state_t;
endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic [WIDTH-1:0] q_prev_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
            prev_q <= '1;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign q_o      = stage_q[STAGES-1];
    assign q_prev_o = prev_q;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank #(
    parameter int NUM_REGS = 8,
    parameter int DW       = 8,
    localparam int PW      = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we_i,
    input  logic [PW-1:0] bus_idx_i,
    input  logic [DW-1:0] bus_data_i,
    input  logic          host_we_i,
    input  logic [PW-1:0] host_idx_i,
    input  logic [DW-1:0] host_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    logic [NUM_REGS*DW-1:0] flat_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                r_q <= '0;
            else if (bus_we_i && bus_idx_i == PW'(g))
                r_q <= bus_data_i;
            else if (host_we_i && host_idx_i == PW'(g))
                r_q <= host_data_i;
        end
        assign flat_q[g*DW +: DW] = r_q;
    end

    assign rd_data_o = flat_q[rd_idx_i*DW +: DW];
endmodule

// File: rtl/rtc_bus_target.sv
module rtc_bus_target
    import rtc_bus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 8,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic       supply_fault_i,
    input  logic       tick_we_i,
    input  logic [2:0] tick_sel_i,
    input  logic [7:0] tick_data_i
);
    localparam int PW = $clog2(NUM_REGS);
    localparam int BW = $clog2(DW + 1);
    localparam logic [BW-1:0] BITS_FULL = BW'(DW);
    localparam logic [BW-1:0] BITS_LAST = BW'(DW - 1);
    localparam logic [PW-1:0] LAST_IDX  = PW'(NUM_REGS - 1);

    logic [1:0] line_s, line_p;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, start_det, stop_det;

    bus_state_t    state, state_d;
    logic [DW-1:0] shreg;
    logic [BW-1:0] cnt;
    logic [PW-1:0] ptr, ptr_next;
    logic          is_read, first_byte, nack_seen;
    logic          addr_hit, byte_done, wr_commit, bus_we;
    logic [DW-1:0] rd_data;

    rtc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}),
        .q_o(line_s), .q_prev_o(line_p)
    );

    assign {scl_s, sda_s} = line_s;
    assign {scl_p, sda_p} = line_p;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    assign addr_hit  = (shreg[DW-1:1] == DEV_ADDR);
    assign byte_done = scl_fall && (cnt == BITS_FULL);
    assign ptr_next  = (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
    assign wr_commit = (state == ST_WR_BYTE) && byte_done && !supply_fault_i && !start_det;
    assign bus_we    = wr_commit && !first_byte;

    rtc_regbank #(.NUM_REGS(NUM_REGS), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .bus_we_i(bus_we), .bus_idx_i(ptr), .bus_data_i(shreg),
        .host_we_i(tick_we_i), .host_idx_i(tick_sel_i[PW-1:0]), .host_data_i(tick_data_i),
        .rd_idx_i(ptr), .rd_data_o(rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        if (supply_fault_i)
            state_d = ST_LOCK;
        else if (state == ST_LOCK)
            state_d = ST_IDLE;
        else if (start_det)
            state_d = ST_ADDR;
        else if (stop_det)
            state_d = ST_IDLE;
        else begin
            unique case (state)
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = is_read ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)  state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && cnt == BITS_LAST) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  state_d = nack_seen ? ST_IGNORE : ST_RD_BYTE;
                default:     state_d = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // datapath: shift register, bit counter, pointer, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0; cnt <= '0; ptr <= '0;
            is_read <= 1'b0; first_byte <= 1'b0; nack_seen <= 1'b0;
        end else if (supply_fault_i) begin
            ptr <= '0; cnt <= '0; first_byte <= 1'b0; nack_seen <= 1'b0;
        end else if (start_det) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise && cnt != BITS_FULL) begin
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            is_read    <= shreg[0];
                            first_byte <= 1'b1;
                        end else begin
                            ptr        <= first_byte ? shreg[PW-1:0] : ptr_next;
                            first_byte <= 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall && is_read) shreg <= rd_data;
                ST_RD_BYTE: if (scl_fall) begin
                    shreg <= {shreg[DW-2:0], 1'b1};
                    if (cnt == BITS_LAST) begin
                        cnt       <= '0;
                        ptr       <= ptr_next;
                        nack_seen <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack_seen <= sda_s;
                    if (scl_fall && !nack_seen) shreg <= rd_data;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_BYTE:             sda_pull_o = ~shreg[DW-1];
            default:                sda_pull_o = 1'b0;
        endcase
    end

    assert_fault_locks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault_i |=> (state == ST_LOCK && ptr == '0 && !sda_pull_o));

    assert_lock_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |-> (!sda_pull_o && !bus_we));

    assert_lock_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !supply_fault_i) |=> (state == ST_IDLE));

    assert_ignore_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_o);

    assert_read_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RD_ACK) |->
            (ptr == (($past(ptr) == LAST_IDX) ? '0 : $past(ptr) + 1'b1)));

    assert_stop_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !supply_fault_i) |=> (state == ST_IDLE && $stable(ptr)));
endmodule

// File: tb/rtc_bus_target_tb.sv
module rtc_bus_target_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic supply_fault = 1'b0;
    logic tick_we = 1'b0;
    logic [2:0] tick_sel = '0;
    logic [7:0] tick_data = '0;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_bus_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .supply_fault_i(supply_fault),
        .tick_we_i(tick_we), .tick_sel_i(tick_sel), .tick_data_i(tick_data)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        acked = (sda_line == 1'b0);
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; scl_m = 1'b0;
        end
        wq(); sda_m = give_ack ? 1'b0 : 1'b1; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        bit a;
        chk("R1 sda released", int'(sda_pull), 0);
        bus_start();
        send_byte(8'hD1, a);
        chk("R2 read address ack", int'(a), 1);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i != 7, b);
            chk("R1 reset register value", int'(b), 8'h00);
        end
        bus_stop();
    endtask

    task automatic t_write_wrap();
        bit a;
        bus_start();
        send_byte(8'hD0, a); chk("R2 write address ack", int'(a), 1);
        send_byte(8'h06, a); chk("R3 pointer byte ack", int'(a), 1);
        send_byte(8'hA6, a); chk("R3 data ack", int'(a), 1);
        send_byte(8'hA7, a); chk("R3 data ack", int'(a), 1);
        send_byte(8'hA0, a); chk("R5 data ack after wrap", int'(a), 1);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h02, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
    endtask

    task automatic t_read_continue();
        logic [7:0] b;
        bit a;
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(1'b1, b); chk("R7 read resumes at pointer 5", int'(b), 8'h00);
        recv_byte(1'b1, b); chk("R4 register 6", int'(b), 8'hA6);
        recv_byte(1'b1, b); chk("R4 register 7", int'(b), 8'hA7);
        recv_byte(1'b1, b); chk("R5 read wraps to register 0", int'(b), 8'hA0);
        recv_byte(1'b0, b); chk("R4 register 1", int'(b), 8'h00);
        recv_byte(1'b1, b); chk("R6 released after NACK", int'(b), 8'hFF);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic [7:0] b;
        bit a;
        bus_start();
        send_byte(8'hA0, a); chk("R2 foreign address not acked", int'(a), 0);
        send_byte(8'h03, a); chk("R2 byte after foreign address", int'(a), 0);
        send_byte(8'h99, a);
        bus_stop();
        bus_start();
        send_byte(8'hD1, a);
        recv_byte(1'b0, b); chk("R2 pointer and registers untouched", int'(b), 8'h11);
        bus_stop();
    endtask

    task automatic t_fault();
        logic [7:0] b;
        bit a;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h04, a);
        supply_fault = 1'b1; wq();
        chk("R8 sda released on fault", int'(sda_pull), 0);
        send_byte(8'hEE, a); chk("R8 aborted transfer not acked", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a); chk("R9 address ignored during fault", int'(a), 0);
        send_byte(8'h03, a);
        send_byte(8'hBB, a);
        bus_stop();
        supply_fault = 1'b0; wq();
        bus_start();
        send_byte(8'hD1, a); chk("R10 address acked after fault", int'(a), 1);
        recv_byte(1'b1, b); chk("R8 pointer cleared to 0", int'(b), 8'hA0);
        recv_byte(1'b1, b); chk("R8 register 1", int'(b), 8'h00);
        recv_byte(1'b1, b); chk("R9 register 2 intact", int'(b), 8'h11);
        recv_byte(1'b1, b); chk("R9 register 3 not written", int'(b), 8'h22);
        recv_byte(1'b0, b); chk("R8 register 4 not written", int'(b), 8'h33);
        bus_stop();
    endtask

    task automatic t_tick();
        logic [7:0] b;
        bit a;
        @(negedge clk);
        tick_we = 1'b1; tick_sel = 3'd1; tick_data = 8'h42;
        @(negedge clk);
        tick_we = 1'b0;
        bus_start();
        send_byte(8'hD0, a);
        send_byte(8'h01, a);
        bus_start();
        send_byte(8'hD1, a); chk("R2 ack after repeated START", int'(a), 1);
        recv_byte(1'b0, b); chk("R11 host tick value", int'(b), 8'h42);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_wrap();
        t_read_continue();
        t_wrong_addr();
        t_fault();
        t_tick();
        finish_run();
    end
endmodule